// File: doc/BRIEF.md
# Scan-Chained Registered Programmable I/O Cell

This block is one bidirectional I/O cell at the edge of a programmable fabric. Each direction has its own storage element and a bypass selector. The outbound path carries data from the fabric to the pad. The inbound path carries data from the pad back into the fabric. Two static configuration bits choose, per direction, whether the path is purely combinational or goes through its register. Both registers run on one clock and clear on one synchronous reset.

The two registers also form a short serial test chain. Data enters at the scan input, passes through the outbound register, then through the inbound register, and leaves at the scan output. A scan-enable input switches both registers from functional capture to shifting. While it is high, the pair acts as a two-stage shift register.

Each register works in one of three modes on every clock edge. CLEAR loads zero and has the highest priority. SHIFT loads the scan-side input when scan enable is high and reset is low. CAPTURE loads the functional input when both reset and scan enable are low. The data width is a parameter. A width above one gives parallel scan lanes, one lane per bit.

Top module: `iocell_scan_io`

## Requirements
- R1: When `rst` is high at a rising clock edge, both registers become all zeros. This shows on `scan_out`, and on `pad_out` and `pad_to_fab` when their register paths are selected.
- R2: Reset takes priority over shifting and over capture. With `rst` high, the values of `scan_en`, `scan_in`, `fab_to_pad` and `pad_in` have no effect on the registers.
- R3: With `rst` and `scan_en` low, the outbound register loads `fab_to_pad` at the clock edge.
- R4: With `rst` and `scan_en` low, the inbound register loads `pad_in` at the clock edge.
- R5: With `cfg_out_reg` = 0, `pad_out` equals `fab_to_pad` in the same cycle, with no clock edge needed.
- R6: With `cfg_out_reg` = 1, `pad_out` equals the outbound register.
- R7: With `cfg_in_reg` = 0, `pad_to_fab` equals `pad_in` in the same cycle.
- R8: With `cfg_in_reg` = 1, `pad_to_fab` equals the inbound register.
- R9: With `scan_en` high and `rst` low, the outbound register loads `scan_in` and the inbound register loads the old outbound value. The functional inputs are ignored, so a value on `scan_in` reaches `scan_out` after two clock edges.
- R10: `scan_out` always equals the inbound register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both registers |
| rst | input | 1 | Synchronous active-high reset to zero |
| scan_en | input | 1 | 1 = shift the chain, 0 = functional capture |
| scan_in | input | DATA_W | Serial test data into the outbound register |
| scan_out | output | DATA_W | Serial test data from the inbound register |
| cfg_out_reg | input | 1 | Outbound select: 0 = bypass, 1 = registered |
| cfg_in_reg | input | 1 | Inbound select: 0 = bypass, 1 = registered |
| fab_to_pad | input | DATA_W | Data from the fabric toward the pad |
| pad_to_fab | output | DATA_W | Data from the pad toward the fabric |
| pad_in | input | DATA_W | Value received at the pad |
| pad_out | output | DATA_W | Value driven toward the pad |

## Verification
Reset and shifting can both be requested at the same edge. The same holds for reset and functional capture. To provoke the first case, the bench fills the chain with ones by shifting. It then raises reset while scan enable stays high and a one sits on `scan_in`. To provoke the second case, it raises reset while ones sit on both functional inputs. In both cases it judges the result after the edge: `scan_out` and both registered paths must read zero, which shows that reset won. A separate shift with ones on the functional inputs shows that shifting in turn overrides capture.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

    // Action a cell register takes at the next clock edge
    typedef enum logic [1:0] {
        OP_CAPTURE = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_CLEAR   = 2'd2
    } cell_op_e;

    // Reset first, then scan, then functional capture
    function automatic cell_op_e pick_op(input logic rst, input logic scan_en);
        if (rst)          return OP_CLEAR;
        else if (scan_en) return OP_SHIFT;
        else              return OP_CAPTURE;
    endfunction

endpackage

// File: rtl/iocell_scan_reg.sv
module iocell_scan_reg
    import iocell_pkg::*;
#(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         scan_en,
    input  logic [W-1:0] d_func,
    input  logic [W-1:0] d_scan,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] ZERO = '0;

    cell_op_e op;

    always_comb begin
        op = pick_op(rst, scan_en);
    end

    always_ff @(posedge clk) begin
        unique case (op)
            OP_CLEAR:   q <= ZERO;
            OP_SHIFT:   q <= d_scan;
            OP_CAPTURE: q <= d_func;
            default:    q <= ZERO;
        endcase
    end

    assert_clear_R1: assert property (@(posedge clk)
        rst |=> (q == ZERO));

    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> (q == $past(d_func)));

    assert_shift_R9: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (q == $past(d_scan)));

endmodule

// File: rtl/iocell_path_sel.sv
module iocell_path_sel #(
    parameter int W = 1
) (
    input  logic         use_reg,
    input  logic [W-1:0] direct_in,
    input  logic [W-1:0] reg_in,
    output logic [W-1:0] y
);

    always_comb begin
        y = use_reg ? reg_in : direct_in;
    end

endmodule

// File: rtl/iocell_scan_io.sv
module iocell_scan_io #(
    parameter int DATA_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic [DATA_W-1:0] scan_in,
    output logic [DATA_W-1:0] scan_out,
    input  logic              cfg_out_reg,
    input  logic              cfg_in_reg,
    input  logic [DATA_W-1:0] fab_to_pad,
    output logic [DATA_W-1:0] pad_to_fab,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] pad_out
);

    logic [DATA_W-1:0] out_q;   // outbound register, first in the chain
    logic [DATA_W-1:0] in_q;    // inbound register, second in the chain

    iocell_scan_reg #(.W(DATA_W)) u_out_reg (
        .clk     (clk),
        .rst     (rst),
        .scan_en (scan_en),
        .d_func  (fab_to_pad),
        .d_scan  (scan_in),
        .q       (out_q)
    );

    iocell_scan_reg #(.W(DATA_W)) u_in_reg (
        .clk     (clk),
        .rst     (rst),
        .scan_en (scan_en),
        .d_func  (pad_in),
        .d_scan  (out_q),
        .q       (in_q)
    );

    iocell_path_sel #(.W(DATA_W)) u_out_sel (
        .use_reg   (cfg_out_reg),
        .direct_in (fab_to_pad),
        .reg_in    (out_q),
        .y         (pad_out)
    );

    iocell_path_sel #(.W(DATA_W)) u_in_sel (
        .use_reg   (cfg_in_reg),
        .direct_in (pad_in),
        .reg_in    (in_q),
        .y         (pad_to_fab)
    );

    assign scan_out = in_q;

    // Two shifts in a row carry scan_in through both stages to scan_out
    assert_chain_depth_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(scan_en) && !$past(rst) && $past(scan_en, 2) && !$past(rst, 2))
        |-> (scan_out == $past(scan_in, 2)));

    assert_reset_wins_R2: assert property (@(posedge clk)
        (rst && scan_en) |=> (scan_out == '0) && (out_q == '0));

    assert_inbound_capture_R4: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> (scan_out == $past(pad_in)));

    assert_out_bypass_R5: assert property (@(posedge clk)
        !cfg_out_reg |-> (pad_out == fab_to_pad));

    assert_in_bypass_R7: assert property (@(posedge clk)
        !cfg_in_reg |-> (pad_to_fab == pad_in));

endmodule

// File: tb/iocell_scan_io_tb.sv
module iocell_scan_io_tb;

    localparam int W = 1;
    localparam logic [W-1:0] ONE = '1;
    localparam logic [W-1:0] ZER = '0;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         scan_en = 1'b0;
    logic [W-1:0] scan_in = '0;
    logic [W-1:0] scan_out;
    logic         cfg_out_reg = 1'b0;
    logic         cfg_in_reg = 1'b0;
    logic [W-1:0] fab_to_pad = '0;
    logic [W-1:0] pad_to_fab;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    iocell_scan_io #(.DATA_W(W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .scan_en     (scan_en),
        .scan_in     (scan_in),
        .scan_out    (scan_out),
        .cfg_out_reg (cfg_out_reg),
        .cfg_in_reg  (cfg_in_reg),
        .fab_to_pad  (fab_to_pad),
        .pad_to_fab  (pad_to_fab),
        .pad_in      (pad_in),
        .pad_out     (pad_out)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one edge, then let outputs settle
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset_state();
        rst = 1'b1; scan_en = 1'b0; cfg_out_reg = 1'b1; cfg_in_reg = 1'b1;
        fab_to_pad = ONE; pad_in = ONE;
        tick();
        check("R1", "scan_out after reset", scan_out, ZER);
        check("R1", "registered pad_out after reset", pad_out, ZER);
        check("R1", "registered pad_to_fab after reset", pad_to_fab, ZER);
        rst = 1'b0;
    endtask

    task automatic t_out_bypass();
        cfg_out_reg = 1'b0;
        fab_to_pad = ONE; #1;
        check("R5", "bypass pad_out high", pad_out, ONE);
        fab_to_pad = ZER; #1;
        check("R5", "bypass pad_out low", pad_out, ZER);
    endtask

    task automatic t_in_bypass();
        cfg_in_reg = 1'b0;
        pad_in = ONE; #1;
        check("R7", "bypass pad_to_fab high", pad_to_fab, ONE);
        pad_in = ZER; #1;
        check("R7", "bypass pad_to_fab low", pad_to_fab, ZER);
    endtask

    task automatic t_out_reg();
        cfg_out_reg = 1'b1; scan_en = 1'b0;
        fab_to_pad = ONE; #1;
        check("R6", "registered pad_out before edge", pad_out, ZER);
        tick();
        check("R3", "outbound capture of one", pad_out, ONE);
        fab_to_pad = ZER; #1;
        check("R6", "registered pad_out holds between edges", pad_out, ONE);
        tick();
        check("R3", "outbound capture of zero", pad_out, ZER);
    endtask

    task automatic t_in_reg();
        cfg_in_reg = 1'b1; scan_en = 1'b0;
        pad_in = ONE; #1;
        check("R8", "registered pad_to_fab before edge", pad_to_fab, ZER);
        tick();
        check("R4", "inbound capture of one", pad_to_fab, ONE);
        check("R10", "scan_out follows inbound register", scan_out, ONE);
        pad_in = ZER;
        tick();
        check("R4", "inbound capture of zero", pad_to_fab, ZER);
    endtask

    task automatic t_scan_shift();
        cfg_out_reg = 1'b1; cfg_in_reg = 1'b1;
        fab_to_pad = ZER; pad_in = ZER;
        tick();   // both registers now zero
        scan_en = 1'b1; fab_to_pad = ONE; pad_in = ONE;
        scan_in = ONE;
        tick();
        check("R9", "first stage loads scan_in", pad_out, ONE);
        check("R9", "scan_out after one shift", scan_out, ZER);
        scan_in = ZER;
        tick();
        check("R9", "first stage loads zero, functional input ignored", pad_out, ZER);
        check("R9", "scan_out after two shifts", scan_out, ONE);
        tick();
        check("R9", "scan_out after three shifts", scan_out, ZER);
        check("R10", "registered pad_to_fab matches scan_out", pad_to_fab, ZER);
        scan_en = 1'b0;
    endtask

    task automatic t_reset_during_scan();
        cfg_out_reg = 1'b1; cfg_in_reg = 1'b1;
        scan_en = 1'b1; scan_in = ONE;
        tick(); tick();
        check("R9", "chain filled with ones", scan_out, ONE);
        rst = 1'b1;
        tick();
        check("R2", "reset beats shift on scan_out", scan_out, ZER);
        check("R2", "reset beats shift on outbound", pad_out, ZER);
        rst = 1'b0; scan_en = 1'b0;
    endtask

    task automatic t_reset_during_capture();
        cfg_out_reg = 1'b1; cfg_in_reg = 1'b1; scan_en = 1'b0;
        fab_to_pad = ONE; pad_in = ONE;
        tick();
        check("R3", "outbound loaded before reset", pad_out, ONE);
        rst = 1'b1;
        tick();
        check("R2", "reset beats capture on outbound", pad_out, ZER);
        check("R2", "reset beats capture on inbound", pad_to_fab, ZER);
        rst = 1'b0; fab_to_pad = ZER; pad_in = ZER;
    endtask

    initial begin
        #(200000 * 20);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_out_bypass();
        t_in_bypass();
        t_out_reg();
        t_in_reg();
        t_scan_shift();
        t_reset_during_scan();
        t_reset_during_capture();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule